// File: doc/BRIEF.md
# Multiplexed LCD Drive Waveform Sequencer

This block produces the drive-level selects for a passive LCD panel with four backplane (common) lines and a 1/3-bias, 1/4-duty drive scheme. A prescaler divides the core clock into duty slots. Each frame has four slots, and each slot selects one common line. In every slot the block outputs a 2-bit level code for each common line and each segment line. An external resistor ladder and its buffers turn each code into one of four analog levels: ground, 1/3, 2/3 and the top supply.

Segment patterns are held in an internal bank with one row per common line and one bit per segment. The row for the coming slot is captured when that slot starts, so a write never changes an output in the middle of a slot. Drive polarity flips every frame, which keeps the average DC across every pixel at zero. A frame strobe marks the first cycle of slot 0. Pulling the enable low stops the sequencer and forces every line to ground.

Top module: `lcd_mux_seq`

## Requirements
- R1: While running, exactly one common line is at its selection level in each slot. The slots select COM0, COM1, COM2 and COM3 in that order, and then the order repeats.
- R2: A slot lasts `div_i`+1 clock cycles, so `div_i`=3 gives divide-by-4. A frame lasts four slots.
- R3: The level codes are 2'b11 = top, 2'b10 = 2/3, 2'b01 = 1/3 and 2'b00 = ground. Each common uses bits [2c+1:2c] of `com_o`. In a positive frame, the selected common gets 2'b11 and the others get 2'b01. In a negative frame, the selected common gets 2'b00 and the others get 2'b10.
- R4: Segment j uses bits [2j+1:2j] of `seg_o`. In slot s, segment j is on when bank bit [s][j] is 1. An on segment gets 2'b00 in a positive frame and 2'b11 in a negative frame. An off segment gets 2'b10 in a positive frame and 2'b01 in a negative frame.
- R5: The first frame after enable is positive, and polarity then alternates every frame.
- R6: While `en_i` is low at a clock edge, every output is 2'b00 after that edge and `frame_o` is 0. After `en_i` returns high, the first loaded slot is slot 0 in a positive frame.
- R7: `frame_o` is high for exactly one cycle, which is the first cycle of each slot 0.
- R8: A bank write takes effect at the next slot start only. Outputs of the current slot do not change.
- R9: Bank contents are kept while the block is disabled.
- R10: After `rst_ni`, all outputs are 0 and every bank bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Sequencer enable |
| div_i | input | DIV_W | Slot length minus one, in clock cycles |
| wr_i | input | 1 | Bank row write strobe |
| wr_row_i | input | 2 | Bank row (common index) to write |
| wr_bits_i | input | NUM_SEG | Segment bits for the written row |
| com_o | output | 8 | Common level codes, 2 bits per line |
| seg_o | output | 2*NUM_SEG | Segment level codes, 2 bits per line |
| frame_o | output | 1 | One-cycle frame-start strobe |

## Verification
The assertions check the codes one edge after a high enable, and they assume that the level codes on the outputs then come from the loaded slot. They rely on `div_i` staying constant while the block runs. The stimulus changes `div_i` only while `en_i` is low. It issues bank writes at any cycle, including in the middle of a slot. The expected stream is built from the slot length in force, the cycle index since enable, and a bank copy captured at each slot start.

// File: rtl/lcd_pkg.sv
package lcd_pkg;
  localparam int NUM_COM = 4;
  localparam int COM_W   = 2;

  typedef enum logic [1:0] {
    LVL_GND = 2'b00,
    LVL_LO  = 2'b01,
    LVL_HI  = 2'b10,
    LVL_TOP = 2'b11
  } lvl_e;

  function automatic lvl_e com_lvl(input logic sel, input logic neg);
    if (!neg) return sel ? LVL_TOP : LVL_LO;
    else      return sel ? LVL_GND : LVL_HI;
  endfunction

  // on segments sit opposite the selected common
  function automatic lvl_e seg_lvl(input logic on, input logic neg);
    if (!neg) return on ? LVL_GND : LVL_HI;
    else      return on ? LVL_TOP : LVL_LO;
  endfunction
endpackage

// File: rtl/lcd_slot_timer.sv
module lcd_slot_timer
  import lcd_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             load_o,
  output logic [COM_W-1:0] slot_nxt_o,
  output logic             neg_nxt_o
);
  logic             run_q;
  logic [DIV_W-1:0] cnt_q;
  logic [COM_W-1:0] slot_q;
  logic             neg_q;
  logic             adv;
  logic             last_slot;

  assign adv       = run_q && (cnt_q >= div_i);
  assign last_slot = (slot_q == COM_W'(NUM_COM - 1));
  assign load_o    = en_i && (!run_q || adv);

  always_comb begin
    if (!run_q) begin
      slot_nxt_o = '0;
      neg_nxt_o  = 1'b0;
    end else begin
      slot_nxt_o = slot_q + COM_W'(1);
      neg_nxt_o  = last_slot ? ~neg_q : neg_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      cnt_q  <= '0;
      slot_q <= '0;
      neg_q  <= 1'b0;
    end else if (!en_i) begin
      run_q  <= 1'b0;
      cnt_q  <= '0;
      slot_q <= '0;
      neg_q  <= 1'b0;
    end else begin
      run_q <= 1'b1;
      if (load_o) begin
        cnt_q  <= '0;
        slot_q <= slot_nxt_o;
        neg_q  <= neg_nxt_o;
      end else begin
        cnt_q <= cnt_q + DIV_W'(1);
      end
    end
  end
endmodule

// File: rtl/lcd_seg_bank.sv
module lcd_seg_bank
  import lcd_pkg::*;
#(
  parameter int NUM_SEG = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  logic [COM_W-1:0]   wr_row_i,
  input  logic [NUM_SEG-1:0] wr_bits_i,
  input  logic [COM_W-1:0]   rd_row_i,
  output logic [NUM_SEG-1:0] rd_bits_o
);
  logic [NUM_SEG-1:0] row_q [NUM_COM];

  for (genvar r = 0; r < NUM_COM; r++) begin : g_row
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              row_q[r] <= '0;
      else if (wr_i && wr_row_i == COM_W'(r))   row_q[r] <= wr_bits_i;
    end
  end

  assign rd_bits_o = row_q[rd_row_i];
endmodule

// File: rtl/lcd_drive_enc.sv
module lcd_drive_enc
  import lcd_pkg::*;
#(
  parameter int NUM_SEG = 8
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   en_i,
  input  logic                   load_i,
  input  logic [COM_W-1:0]       slot_i,
  input  logic                   neg_i,
  input  logic [NUM_SEG-1:0]     bits_i,
  output logic [2*NUM_COM-1:0]   com_o,
  output logic [2*NUM_SEG-1:0]   seg_o,
  output logic                   frame_o
);
  for (genvar c = 0; c < NUM_COM; c++) begin : g_com
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     com_o[2*c+:2] <= LVL_GND;
      else if (!en_i)  com_o[2*c+:2] <= LVL_GND;
      else if (load_i) com_o[2*c+:2] <= com_lvl(slot_i == COM_W'(c), neg_i);
    end
  end

  for (genvar j = 0; j < NUM_SEG; j++) begin : g_seg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     seg_o[2*j+:2] <= LVL_GND;
      else if (!en_i)  seg_o[2*j+:2] <= LVL_GND;
      else if (load_i) seg_o[2*j+:2] <= seg_lvl(bits_i[j], neg_i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    frame_o <= 1'b0;
    else if (!en_i) frame_o <= 1'b0;
    else            frame_o <= load_i && (slot_i == '0);
  end
endmodule

// File: rtl/lcd_mux_seq.sv
module lcd_mux_seq
  import lcd_pkg::*;
#(
  parameter int NUM_SEG = 8,
  parameter int DIV_W   = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_i,
  input  logic [DIV_W-1:0]     div_i,
  input  logic                 wr_i,
  input  logic [1:0]           wr_row_i,
  input  logic [NUM_SEG-1:0]   wr_bits_i,
  output logic [7:0]           com_o,
  output logic [2*NUM_SEG-1:0] seg_o,
  output logic                 frame_o
);
  logic               load;
  logic [COM_W-1:0]   slot_nxt;
  logic               neg_nxt;
  logic [NUM_SEG-1:0] row_bits;

  lcd_slot_timer #(.DIV_W(DIV_W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_i),
    .div_i      (div_i),
    .load_o     (load),
    .slot_nxt_o (slot_nxt),
    .neg_nxt_o  (neg_nxt)
  );

  lcd_seg_bank #(.NUM_SEG(NUM_SEG)) u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (wr_i),
    .wr_row_i  (wr_row_i),
    .wr_bits_i (wr_bits_i),
    .rd_row_i  (slot_nxt),
    .rd_bits_o (row_bits)
  );

  lcd_drive_enc #(.NUM_SEG(NUM_SEG)) u_enc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en_i),
    .load_i  (load),
    .slot_i  (slot_nxt),
    .neg_i   (neg_nxt),
    .bits_i  (row_bits),
    .com_o   (com_o),
    .seg_o   (seg_o),
    .frame_o (frame_o)
  );
endmodule

// File: rtl/lcd_mux_seq_chk.sv
module lcd_mux_seq_chk #(
  parameter int NUM_SEG = 8
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 en_i,
  input logic [7:0]           com_o,
  input logic [2*NUM_SEG-1:0] seg_o,
  input logic                 frame_o
);
  logic [2:0] sel_cnt;
  logic       pos_ok;
  logic       neg_ok;

  always_comb begin
    sel_cnt = '0;
    pos_ok  = 1'b1;
    neg_ok  = 1'b1;
    for (int c = 0; c < 4; c++) begin
      if (com_o[2*c+:2] == 2'b11 || com_o[2*c+:2] == 2'b00) sel_cnt = sel_cnt + 3'd1;
      if (com_o[2*c+:2] == 2'b10 || com_o[2*c+:2] == 2'b00) pos_ok = 1'b0;
      if (com_o[2*c+:2] == 2'b11 || com_o[2*c+:2] == 2'b01) neg_ok = 1'b0;
    end
    for (int j = 0; j < NUM_SEG; j++) begin
      if (seg_o[2*j+:2] == 2'b11 || seg_o[2*j+:2] == 2'b01) pos_ok = 1'b0;
      if (seg_o[2*j+:2] == 2'b00 || seg_o[2*j+:2] == 2'b10) neg_ok = 1'b0;
    end
  end

  // R6
  disabled_ground_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (com_o == '0 && seg_o == '0 && !frame_o));

  // R1
  one_selected_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> (sel_cnt == 3'd1));

  // R3
  polarity_consistent_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> (pos_ok || neg_ok));

  // R7
  frame_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_o |=> !frame_o);

  // R7
  frame_com0_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_o |-> (com_o[1:0] == 2'b11 || com_o[1:0] == 2'b00));
endmodule

bind lcd_mux_seq lcd_mux_seq_chk #(.NUM_SEG(NUM_SEG)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .en_i    (en_i),
  .com_o   (com_o),
  .seg_o   (seg_o),
  .frame_o (frame_o)
);

// File: tb/sim_lcd_mux_seq.sv
`timescale 1ns/1ps
module sim_lcd_mux_seq;
  localparam int NSEG = 8;
  localparam int DW   = 8;

  typedef struct packed {
    logic [7:0]        com;
    logic [2*NSEG-1:0] seg;
    logic              frame;
  } exp_t;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            en_r;
  logic [DW-1:0]   div_r;
  logic            wr_r;
  logic [1:0]      wr_row_r;
  logic [NSEG-1:0] wr_bits_r;
  logic [7:0]          com_o;
  logic [2*NSEG-1:0]   seg_o;
  logic                frame_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  int k      = -1;
  logic [NSEG-1:0] mbank [4];
  logic [NSEG-1:0] cap;
  exp_t exp_q [$];

  always #2 clk = ~clk;

  lcd_mux_seq #(.NUM_SEG(NSEG), .DIV_W(DW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en_r), .div_i(div_r),
    .wr_i(wr_r), .wr_row_i(wr_row_r), .wr_bits_i(wr_bits_r),
    .com_o(com_o), .seg_o(seg_o), .frame_o(frame_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // expected outputs derived from cycle index k since enable (R2, R5)
  function automatic exp_t expect_now();
    exp_t e;
    int L, slot;
    logic neg;
    e = '0;
    if (k < 0) return e;
    L    = int'(div_r) + 1;
    slot = (k / L) % 4;
    neg  = ((k / (4 * L)) % 2) == 1;
    e.frame = (k % (4 * L)) == 0;
    for (int c = 0; c < 4; c++)
      e.com[2*c+:2] = (c == slot) ? (neg ? 2'b00 : 2'b11) : (neg ? 2'b10 : 2'b01);
    for (int j = 0; j < NSEG; j++)
      e.seg[2*j+:2] = cap[j] ? (neg ? 2'b11 : 2'b00) : (neg ? 2'b01 : 2'b10);
    return e;
  endfunction

  // driver: one clock edge, model update, push expected item
  task automatic step();
    @(posedge clk); #1;
    if (!en_r) k = -1;
    else       k = k + 1;
    if (k >= 0 && (k % (int'(div_r) + 1)) == 0)
      cap = mbank[(k / (int'(div_r) + 1)) % 4];  // R8: captured at slot start
    if (wr_r) mbank[wr_row_r] = wr_bits_r;
    exp_q.push_back(expect_now());
    wr_r = 1'b0;
  endtask

  task automatic write_row(input logic [1:0] row, input logic [NSEG-1:0] bits);
    wr_r = 1'b1; wr_row_r = row; wr_bits_r = bits;
    step();
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && exp_q.size() != 0) begin
      exp_t e;
      e = exp_q.pop_front();
      chk("R1 R3 com", 32'(com_o), 32'(e.com));
      chk("R4 R8 R9 seg", 32'(seg_o), 32'(e.seg));
      chk("R2 R7 frame", 32'(frame_o), 32'(e.frame));
    end
  end

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    rst_n = 0; en_r = 0; div_r = 8'd3; wr_r = 0; wr_row_r = '0; wr_bits_r = '0;
    for (int i = 0; i < 4; i++) mbank[i] = '0;
    cap = '0;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 com", 32'(com_o), 32'h0);
    chk("R10 seg", 32'(seg_o), 32'h0);
    chk("R10 frame", 32'(frame_o), 32'h0);
    @(posedge clk); #1;
    rst_n = 1;
    step(); step();
    // R10: empty bank shows all segments off, divide-by-4 (R2)
    en_r = 1; step();
    repeat (16) step();
    en_r = 0; step(); step();
    // load patterns while disabled
    write_row(2'd0, 8'hA5);
    write_row(2'd1, 8'h3C);
    write_row(2'd2, 8'hFF);
    write_row(2'd3, 8'h00);
    step();
    // R1 R3 R4 R5: three frames at divide-by-4, with a mid-slot write (R8)
    en_r = 1; step();
    while (k < 20) step();
    write_row(2'd1, 8'hC3);
    while (k < 47) step();
    // R6: disable, outputs ground, then restart at slot 0 positive
    en_r = 0;
    repeat (5) step();
    // R9: bank retained, slot length one cycle
    div_r = 8'd0;
    en_r = 1; step();
    repeat (12) step();
    write_row(2'd2, 8'h5A);
    repeat (6) step();
    en_r = 0; step(); step();
    // longer slot, write at slot boundary region
    div_r = 8'd5;
    en_r = 1; step();
    repeat (30) step();
    write_row(2'd0, 8'h0F);
    repeat (20) step();
    en_r = 0; step(); step();
    @(negedge clk);
    @(negedge clk);
    finish_up();
  end
endmodule